// File: doc/BRIEF.md
# Aliased Multi-Width Register File

This block holds sixteen 64-bit general-purpose registers. They can be read and written at byte, word, doubleword or quadword width. Narrow widths are views into the same storage, not separate registers. There is one write port and two read ports.

Every port carries a 4-bit register index, a 2-bit operand size and an extension flag. The extension flag does two things. It opens up the upper eight registers and the quadword size. It also changes how byte indices 4 to 7 map onto storage: with the flag clear, those indices reach the second byte of the first four registers; with it set, they reach the low byte of registers 4 to 7.

The merge rules differ by width:
- Byte and word writes touch only their own slice.
- A doubleword write clears the upper half of the register.
- All narrow reads are zero-extended.

An illegal access does three things: it raises the error output of its port, it blocks the write, and it returns zero on a read. The register file sits beside an instruction decoder, which supplies the index, size and flag for each operand.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets every one of the sixteen registers to zero.
- R2: Index order is A=0, C=1, D=2, B=3, SP=4, BP=5, SI=6, DI=7, X8..X15=8..15. Size code 2'b00 is byte, 2'b01 is word, 2'b10 is doubleword and 2'b11 is quadword. A quadword access with the extension flag set writes or returns all 64 bits of the indexed register.
- R3: A byte access at index 0..3 addresses bits 7:0 of that register. A write leaves bits 63:8 unchanged, and a read returns the byte zero-extended.
- R4: With the extension flag clear, a byte access at index 4..7 addresses bits 15:8 of register index-4. Other bits and other registers are unchanged, and a read returns that byte zero-extended.
- R5: With the extension flag set, a byte access at index 4..7 addresses bits 7:0 of register 4..7 itself. Registers 0..3 are not touched.
- R6: A word access addresses bits 15:0. A write keeps bits 63:16, and a read returns the word zero-extended.
- R7: A doubleword write stores bits 31:0 and clears bits 63:32. A doubleword read returns bits 31:0 zero-extended.
- R8: An access at index 8..15 with the extension flag clear is illegal. The port's error output is high, a write leaves every register unchanged, and a read returns zero.
- R9: A quadword access with the extension flag clear is illegal, with the same error, write-suppression and zero-read behaviour as R8.
- R10: A read of the register being written in the same cycle by a legal write returns the merged value that will be stored at the next edge.
- R11: The two read ports decode and return data independently. Each may address any register at any size in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write operand size |
| wr_ext | input | 1 | Write extension flag |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Write request is illegal and was dropped |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 operand size |
| rd0_ext | input | 1 | Read port 0 extension flag |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 access is illegal |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 operand size |
| rd1_ext | input | 1 | Read port 1 extension flag |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 access is illegal |

## Verification
The assertions assume that every input is at a known value whenever reset is low. They also assume reset is held for at least one rising edge before the first access.

The stability check for read data needs the read fields to be unchanged over two cycles while no legal write occurs. The bench drives all inputs on the falling edge and clears `wr_en` between writes, so that window occurs whenever the bench dwells on a read. Every illegal combination the bench drives is one of the two defined in R8 and R9.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

    localparam int XLEN  = 64;
    localparam int NREGS = 16;
    localparam int IDXW  = $clog2(NREGS);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_QWORD = 2'b11
    } opsize_e;

    // Result of decoding one port's index, size and flag.
    typedef struct packed {
        logic            legal;
        logic            hi_byte;
        logic [IDXW-1:0] phys;
    } slot_t;

endpackage

// File: rtl/arf_decode.sv
module arf_decode
    import alias_rf_pkg::*;
#(
    parameter int LEGACY_REGS    = 8,
    parameter int HIGH_BYTE_REGS = 4
) (
    input  logic [IDXW-1:0] idx,
    input  opsize_e         size,
    input  logic            ext,
    output slot_t           slot
);

    localparam logic [IDXW-1:0] LEG_LIMIT = IDXW'(LEGACY_REGS);
    localparam logic [IDXW-1:0] HB_BASE   = IDXW'(HIGH_BYTE_REGS);
    localparam logic [IDXW-1:0] HB_LIMIT  = IDXW'(2 * HIGH_BYTE_REGS);

    logic beyond_legacy;
    logic in_hb_window;

    always_comb begin
        beyond_legacy = (idx >= LEG_LIMIT);
        in_hb_window  = (idx >= HB_BASE) && (idx < HB_LIMIT);

        slot.legal    = ext || (!beyond_legacy && (size != SZ_QWORD));
        slot.hi_byte  = !ext && (size == SZ_BYTE) && in_hb_window;
        slot.phys     = slot.hi_byte ? (idx - HB_BASE) : idx;
    end

endmodule

// File: rtl/arf_merge.sv
module arf_merge
    import alias_rf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] data,
    input  opsize_e      size,
    input  logic         hi_byte,
    output logic [W-1:0] new_val
);

    always_comb begin
        new_val = old_val;
        unique case (size)
            SZ_BYTE: begin
                if (hi_byte) new_val[15:8] = data[7:0];
                else         new_val[7:0]  = data[7:0];
            end
            SZ_WORD:  new_val[15:0] = data[15:0];
            SZ_DWORD: new_val       = W'(data[31:0]);
            SZ_QWORD: new_val       = data;
            default:  new_val       = old_val;
        endcase
    end

endmodule

// File: rtl/arf_view.sv
module arf_view
    import alias_rf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] reg_val,
    input  opsize_e      size,
    input  logic         hi_byte,
    input  logic         legal,
    output logic [W-1:0] data_o
);

    always_comb begin
        data_o = '0;
        if (legal) begin
            unique case (size)
                SZ_BYTE:  data_o = hi_byte ? W'(reg_val[15:8]) : W'(reg_val[7:0]);
                SZ_WORD:  data_o = W'(reg_val[15:0]);
                SZ_DWORD: data_o = W'(reg_val[31:0]);
                SZ_QWORD: data_o = reg_val;
                default:  data_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
    import alias_rf_pkg::*;
#(
    parameter int LEGACY_REGS    = 8,
    parameter int HIGH_BYTE_REGS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_size,
    input  logic            wr_ext,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_err,
    input  logic [IDXW-1:0] rd0_idx,
    input  logic [1:0]      rd0_size,
    input  logic            rd0_ext,
    output logic [XLEN-1:0] rd0_data,
    output logic            rd0_err,
    input  logic [IDXW-1:0] rd1_idx,
    input  logic [1:0]      rd1_size,
    input  logic            rd1_ext,
    output logic [XLEN-1:0] rd1_data,
    output logic            rd1_err
);

    localparam int NRD = 2;

    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] regs;
    } rf_state_t;

    rf_state_t state_d, state_q;

    // ---------------- write path ----------------
    slot_t           wr_slot;
    logic [XLEN-1:0] wr_merged;
    logic            wr_fire;

    arf_decode #(
        .LEGACY_REGS    (LEGACY_REGS),
        .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
    ) u_wr_dec (
        .idx  (wr_idx),
        .size (opsize_e'(wr_size)),
        .ext  (wr_ext),
        .slot (wr_slot)
    );

    arf_merge #(.W(XLEN)) u_wr_merge (
        .old_val (state_q.regs[wr_slot.phys]),
        .data    (wr_data),
        .size    (opsize_e'(wr_size)),
        .hi_byte (wr_slot.hi_byte),
        .new_val (wr_merged)
    );

    assign wr_fire = wr_en && wr_slot.legal;
    assign wr_err  = wr_en && !wr_slot.legal;

    always_comb begin
        state_d = state_q;
        if (wr_fire) begin
            state_d.regs[wr_slot.phys] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    // ---------------- read paths ----------------
    logic [IDXW-1:0] rp_idx  [NRD];
    logic [1:0]      rp_size [NRD];
    logic            rp_ext  [NRD];
    logic [XLEN-1:0] rp_data [NRD];
    logic            rp_err  [NRD];

    assign rp_idx[0]  = rd0_idx;
    assign rp_size[0] = rd0_size;
    assign rp_ext[0]  = rd0_ext;
    assign rp_idx[1]  = rd1_idx;
    assign rp_size[1] = rd1_size;
    assign rp_ext[1]  = rd1_ext;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        slot_t rs;

        arf_decode #(
            .LEGACY_REGS    (LEGACY_REGS),
            .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
        ) u_dec (
            .idx  (rp_idx[p]),
            .size (opsize_e'(rp_size[p])),
            .ext  (rp_ext[p]),
            .slot (rs)
        );

        // Reading the next-state image gives write-through bypass.
        arf_view #(.W(XLEN)) u_view (
            .reg_val (state_d.regs[rs.phys]),
            .size    (opsize_e'(rp_size[p])),
            .hi_byte (rs.hi_byte),
            .legal   (rs.legal),
            .data_o  (rp_data[p])
        );

        assign rp_err[p] = !rs.legal;
    end

    assign rd0_data = rp_data[0];
    assign rd0_err  = rp_err[0];
    assign rd1_data = rp_data[1];
    assign rd1_err  = rp_err[1];

endmodule

// File: rtl/alias_rf_checker.sv
module alias_rf_checker
    import alias_rf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic [1:0]      wr_size,
    input logic            wr_ext,
    input logic            wr_err,
    input logic [IDXW-1:0] rd0_idx,
    input logic [1:0]      rd0_size,
    input logic            rd0_ext,
    input logic [XLEN-1:0] rd0_data,
    input logic            rd0_err,
    input logic [IDXW-1:0] rd1_idx,
    input logic [1:0]      rd1_size,
    input logic            rd1_ext,
    input logic [XLEN-1:0] rd1_data,
    input logic            rd1_err
);

    AST_RESET_ZEROES: assert property (@(posedge clk)
        rst |=> (wr_en || rd0_data == '0)) else $error("reset"); // R1

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'b00) |-> (rd0_data[63:8] == '0)) else $error("byte zext"); // R3

    AST_WORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd1_size == 2'b01) |-> (rd1_data[63:16] == '0)) else $error("word zext"); // R6

    AST_DWORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'b10) |-> (rd0_data[63:32] == '0)) else $error("dword zext"); // R7

    AST_EXT_IDX_ERR_RD: assert property (@(posedge clk) disable iff (rst)
        (!rd0_ext && rd0_idx >= 4'd8) |-> (rd0_err && rd0_data == '0)) else $error("ext idx rd"); // R8

    AST_EXT_IDX_ERR_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ext && wr_idx >= 4'd8) |-> wr_err) else $error("ext idx wr"); // R8

    AST_QWORD_ERR: assert property (@(posedge clk) disable iff (rst)
        (rd1_size == 2'b11 && !rd1_ext) |-> (rd1_err && rd1_data == '0)) else $error("qword"); // R9

    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && (!wr_en || wr_err) && $past(!wr_en || wr_err)
         && $stable(rd0_idx) && $stable(rd0_size) && $stable(rd0_ext))
        |-> $stable(rd0_data)) else $error("stable"); // R8

endmodule

bind alias_regfile alias_rf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .wr_ext   (wr_ext),
    .wr_err   (wr_err),
    .rd0_idx  (rd0_idx),
    .rd0_size (rd0_size),
    .rd0_ext  (rd0_ext),
    .rd0_data (rd0_data),
    .rd0_err  (rd0_err),
    .rd1_idx  (rd1_idx),
    .rd1_size (rd1_size),
    .rd1_ext  (rd1_ext),
    .rd1_data (rd1_data),
    .rd1_err  (rd1_err)
);

// File: tb/alias_regfile_bench.sv
module alias_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_ext = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [3:0]  rd0_idx = '0;
    logic [1:0]  rd0_size = '0;
    logic        rd0_ext = 1'b0;
    logic [63:0] rd0_data;
    logic        rd0_err;
    logic [3:0]  rd1_idx = '0;
    logic [1:0]  rd1_size = '0;
    logic        rd1_ext = 1'b0;
    logic [63:0] rd1_data;
    logic        rd1_err;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;
    logic [63:0] mdl [16];

    always #5 clk = ~clk;

    alias_regfile u_alias_regfile (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_ext(wr_ext),
        .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_ext(rd0_ext),
        .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_ext(rd1_ext),
        .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One write cycle; returns wr_err sampled mid-cycle.
    task automatic do_write(input logic [3:0] idx, input logic [1:0] sz, input logic ext,
                            input logic [63:0] d, output logic err);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_ext = ext; wr_data = d;
        #1 err = wr_err;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int port, input logic [3:0] idx, input logic [1:0] sz,
                           input logic ext, output logic [63:0] d, output logic err);
        if (port == 0) begin rd0_idx = idx; rd0_size = sz; rd0_ext = ext; end
        else           begin rd1_idx = idx; rd1_size = sz; rd1_ext = ext; end
        #1;
        d   = (port == 0) ? rd0_data : rd1_data;
        err = (port == 0) ? rd0_err  : rd1_err;
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'h0F1E_2D3C_4B5A_6978 ^ ({16{4'(i)}} << 1) ^ (64'(i) << 56);
    endfunction

    task automatic t_qword_all;   // R2, R11
        logic e; logic [63:0] d0, d1;
        for (int i = 0; i < 16; i++) begin
            do_write(4'(i), 2'b11, 1'b1, pat(i), e);
            mdl[i] = pat(i);
        end
        for (int i = 0; i < 16; i++) begin
            do_read(0, 4'(i), 2'b11, 1'b1, d0, e);
            do_read(1, 4'(15 - i), 2'b11, 1'b1, d1, e);
            check("R2 qword readback", d0, mdl[i]);
            check("R11 second port", d1, mdl[15 - i]);
        end
    endtask

    task automatic t_byte_low;    // R3
        logic e; logic [63:0] d;
        do_write(4'd1, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FF5A, e);
        mdl[1] = {mdl[1][63:8], 8'h5A};
        do_read(0, 4'd1, 2'b11, 1'b1, d, e);
        check("R3 low byte merge", d, mdl[1]);
        do_read(0, 4'd1, 2'b00, 1'b0, d, e);
        check("R3 low byte read zext", d, 64'h5A);
    endtask

    task automatic t_high_byte;   // R4
        logic e; logic [63:0] d;
        do_write(4'd6, 2'b00, 1'b0, 64'h0000_0000_0000_00C3, e);
        mdl[2] = {mdl[2][63:16], 8'hC3, mdl[2][7:0]};
        do_read(0, 4'd2, 2'b11, 1'b1, d, e);
        check("R4 high byte lands in reg 2", d, mdl[2]);
        do_read(1, 4'd6, 2'b11, 1'b1, d, e);
        check("R4 reg 6 untouched", d, mdl[6]);
        do_read(0, 4'd6, 2'b00, 1'b0, d, e);
        check("R4 high byte read", d, 64'hC3);
    endtask

    task automatic t_ext_byte;    // R5
        logic e; logic [63:0] d;
        do_write(4'd6, 2'b00, 1'b1, 64'h77, e);
        mdl[6] = {mdl[6][63:8], 8'h77};
        do_read(0, 4'd6, 2'b11, 1'b1, d, e);
        check("R5 low byte of reg 6", d, mdl[6]);
        do_read(1, 4'd2, 2'b11, 1'b1, d, e);
        check("R5 reg 2 untouched", d, mdl[2]);
        do_read(0, 4'd6, 2'b00, 1'b1, d, e);
        check("R5 byte read with flag", d, 64'h77);
    endtask

    task automatic t_word;        // R6
        logic e; logic [63:0] d;
        do_write(4'd11, 2'b01, 1'b1, 64'hAAAA_BBBB_CCCC_1234, e);
        mdl[11] = {mdl[11][63:16], 16'h1234};
        do_read(0, 4'd11, 2'b11, 1'b1, d, e);
        check("R6 word merge", d, mdl[11]);
        do_read(1, 4'd11, 2'b01, 1'b1, d, e);
        check("R6 word read zext", d, 64'h1234);
    endtask

    task automatic t_dword;       // R7
        logic e; logic [63:0] d;
        do_write(4'd5, 2'b10, 1'b0, 64'h1111_2222_8765_4321, e);
        mdl[5] = 64'h0000_0000_8765_4321;
        do_read(0, 4'd5, 2'b11, 1'b1, d, e);
        check("R7 dword clears upper half", d, mdl[5]);
        do_read(0, 4'd2, 2'b10, 1'b0, d, e);
        check("R7 dword read zext", d, {32'h0, mdl[2][31:0]});
    endtask

    task automatic t_illegal;     // R8, R9
        logic e; logic [63:0] d;
        do_write(4'd9, 2'b10, 1'b0, 64'hDEAD, e);
        check("R8 write error flag", 64'(e), 64'd1);
        do_read(0, 4'd9, 2'b11, 1'b1, d, e);
        check("R8 write suppressed", d, mdl[9]);
        do_read(1, 4'd9, 2'b10, 1'b0, d, e);
        check("R8 read data zero", d, 64'h0);
        check("R8 read error flag", 64'(e), 64'd1);
        do_write(4'd0, 2'b11, 1'b0, 64'hBAD0_BAD0_BAD0_BAD0, e);
        check("R9 write error flag", 64'(e), 64'd1);
        do_read(0, 4'd0, 2'b11, 1'b1, d, e);
        check("R9 write suppressed", d, mdl[0]);
        do_read(1, 4'd0, 2'b11, 1'b0, d, e);
        check("R9 read data zero", d, 64'h0);
        check("R9 read error flag", 64'(e), 64'd1);
        do_read(1, 4'd0, 2'b10, 1'b0, d, e);
        check("R9 dword without flag legal", 64'(e), 64'd0);
    endtask

    task automatic t_bypass;      // R10, R11
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd3; wr_size = 2'b10; wr_ext = 1'b0;
        wr_data = 64'hFFFF_FFFF_DEAD_BEEF;
        rd0_idx = 4'd3; rd0_size = 2'b10; rd0_ext = 1'b0;
        rd1_idx = 4'd3; rd1_size = 2'b11; rd1_ext = 1'b1;
        #1;
        check("R10 bypass dword", rd0_data, 64'hDEAD_BEEF);
        check("R10 bypass qword view", rd1_data, 64'h0000_0000_DEAD_BEEF);
        rd1_idx = 4'd4;
        #1;
        check("R11 other port other reg", rd1_data, mdl[4]);
        mdl[3] = 64'h0000_0000_DEAD_BEEF;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 value stored", rd0_data, 64'hDEAD_BEEF);
    endtask

    task automatic t_reset;       // R1
        logic e; logic [63:0] d0, d1;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            do_read(0, 4'(i), 2'b11, 1'b1, d0, e);
            do_read(1, 4'(i), 2'b11, 1'b1, d1, e);
            check("R1 cleared port0", d0, 64'h0);
            check("R1 cleared port1", d1, 64'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        begin
            logic e; logic [63:0] d;
            do_read(0, 4'd7, 2'b11, 1'b1, d, e);
            check("R1 zero after first reset", d, 64'h0);
        end
        t_qword_all();
        t_byte_low();
        t_high_byte();
        t_ext_byte();
        t_word();
        t_dword();
        t_illegal();
        t_bypass();
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

endmodule